// File: doc/BRIEF.md
# Status Register and Write-Permission Guard

This block keeps the status byte of a 1024-byte serial memory and decides, cycle by cycle, whether a write to the array or to the status byte may go ahead. The block is driven by the command decoder, which raises one-cycle strobes for the commands it has already recognised: latch enable, latch disable, status write with its data byte, and array write completion. It also receives the target address of the pending array write, the active-low hardware lock pin and the busy flag of the write timer. The serial front end reads the status byte at any time. It asks the block for two permission signals before it commits a write.

The status byte holds three persistent bits: a lock-enable bit and a two-bit range selector. These bits are plain registers with a reset value. The byte also holds a write-enable latch that clears itself, and it mirrors the busy flag. Array writes are refused inside the address range that the selector protects. Status writes are refused while the lock pin is low and the lock-enable bit is set. The write-enable latch gates both kinds of write, and so does the busy flag.

Top module: `stsreg_guard`

## Requirements
- R1: The status byte `sts_byte` is {lock-enable at bit 7, zeros at bits 6..4, range selector high at bit 3, range selector low at bit 2, write-enable latch at bit 1, busy input at bit 0}. Bit 0 follows `timer_busy` in the same cycle.
- R2: After reset the write-enable latch is 0 and the persistent bits take their reset parameters (all 0 by default), so `sts_byte` is 0x00 while the timer is idle.
- R3: `cmd_wr_en` sets the latch and `cmd_wr_dis` clears it, both on the next edge. Both work while the lock is engaged and while the timer is busy.
- R4: An accepted `cmd_sts_wr` copies `sts_wdata` bits 7, 3 and 2 into the lock-enable bit and the range selector. It ignores the other data bits and clears the latch on the next edge.
- R5: `sts_wr_ok` is 1 exactly when the latch is 1, the timer is idle and the lock is not engaged. The lock is engaged when `lock_pin_n` is 0 and the lock-enable bit is 1. A `cmd_sts_wr` while `sts_wr_ok` is 0 changes neither the persistent bits nor the latch.
- R6: Range selector 0 protects no address. Selector 1 protects the top quarter (0x300..0x3FF). Selector 2 protects the top half (0x200..0x3FF). Selector 3 protects every address.
- R7: `arr_wr_ok` is 1 exactly when the latch is 1, the timer is idle and `arr_addr` lies outside the protected range. The lock pin and the lock-enable bit have no effect on it.
- R8: `arr_wr_done` clears the latch on the next edge.
- R9: When a clearing event (`cmd_wr_dis`, `arr_wr_done` or an accepted status write) falls in the same cycle as `cmd_wr_en`, the latch ends at 0.
- R10: While `timer_busy` is 1 the persistent bits do not change, whatever happens on `lock_pin_n` or `cmd_sts_wr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_wr_en | input | 1 | Strobe: set write-enable latch |
| cmd_wr_dis | input | 1 | Strobe: clear write-enable latch |
| cmd_sts_wr | input | 1 | Strobe: commit a status write |
| sts_wdata | input | 8 | Data byte of the status write |
| arr_wr_done | input | 1 | Strobe: array write finished |
| arr_addr | input | ADDR_W | Address of the pending array write |
| lock_pin_n | input | 1 | Hardware lock pin, active low |
| timer_busy | input | 1 | Write timer busy flag |
| sts_byte | output | 8 | Status byte for reads |
| arr_wr_ok | output | 1 | Array write at `arr_addr` is allowed |
| sts_wr_ok | output | 1 | Status write is allowed |

## Verification
The write-enable latch can be set and cleared in the same cycle. This happens when a latch-enable strobe arrives together with a latch-disable strobe or with an array-completion strobe. The bench drives each of these pairs in a single cycle and expects bit 1 of the status byte to read 0 afterwards. The bench also applies a status write while the timer is busy and toggles the lock pin at the same time, then checks that the persistent bits are unchanged. A full sweep of every range setting, lock setting and address compares both permission signals with values the bench works out from the address arithmetic.

// File: rtl/stsreg_pkg.sv
// Package: shared bit positions and the persistent-bit record of the
// status guard. Assumes an 8-bit status byte.
package stsreg_pkg;
    localparam int STS_W    = 8;
    localparam int POS_LOCK = 7;
    localparam int POS_RNG1 = 3;
    localparam int POS_RNG0 = 2;
    localparam int POS_WEL  = 1;
    localparam int POS_BUSY = 0;

    typedef struct packed {
        logic       lock_en;
        logic [1:0] rng;
    } nv_bits_t;
endpackage

// File: rtl/stsreg_wel.sv
// Write-enable latch. Set by a set request, cleared by any clear request.
// Clear wins over set. Assumes one-cycle strobes from the decoder.
module stsreg_wel (
    input  logic clk,
    input  logic rst_n,
    input  logic set_req,
    input  logic clr_req,
    output logic wel
);
    // Latch update: clear dominates set.
    always_ff @(posedge clk) begin
        if (!rst_n)       wel <= 1'b0;
        else if (clr_req) wel <= 1'b0;
        else if (set_req) wel <= 1'b1;
    end

    p_wel_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (set_req && !clr_req) |=> wel);
    p_wel_clr_r9: assert property (@(posedge clk) disable iff (!rst_n)
        clr_req |=> !wel);
endmodule

// File: rtl/stsreg_nv.sv
// Persistent status bits (lock-enable, range selector) kept as registers
// with a reset value. Loaded only on a commit. Assumes the caller has
// already judged the permission, and that commit is 0 while busy.
module stsreg_nv
    import stsreg_pkg::*;
#(
    parameter logic       RST_LOCK = 1'b0,
    parameter logic [1:0] RST_RNG  = 2'b00
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             commit,
    input  logic             busy,
    input  logic [STS_W-1:0] wdata,
    output nv_bits_t         nv
);
    // Load bits 7, 3 and 2 of the data byte on an accepted commit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nv.lock_en <= RST_LOCK;
            nv.rng     <= RST_RNG;
        end else if (commit) begin
            nv.lock_en <= wdata[POS_LOCK];
            nv.rng     <= {wdata[POS_RNG1], wdata[POS_RNG0]};
        end
    end

    p_nv_hold_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(nv));
endmodule

// File: rtl/stsreg_range.sv
// Address-range protection decode: none, top quarter, top half or all.
// Assumes ADDR_W >= 2.
module stsreg_range #(
    parameter int ADDR_W = 10
) (
    input  logic [1:0]        rng,
    input  logic [ADDR_W-1:0] addr,
    output logic              prot
);
    localparam int TOP = ADDR_W - 1;

    // Decide whether the address falls into the selected protected block.
    always_comb begin
        unique case (rng)
            2'b00:   prot = 1'b0;
            2'b01:   prot = addr[TOP] & addr[TOP-1];
            2'b10:   prot = addr[TOP];
            default: prot = 1'b1;
        endcase
    end

    always_comb begin
        if (rng == 2'b00) p_none_open_r6: assert (!prot);
    end
endmodule

// File: rtl/stsreg_guard.sv
// Status register and write-permission guard of a serial memory. Builds the
// status byte and both permission signals from the latch, the persistent bits,
// the lock pin and the timer busy flag. Assumes command strobes last one cycle.
module stsreg_guard
    import stsreg_pkg::*;
#(
    parameter int         ADDR_W   = 10,
    parameter logic       RST_LOCK = 1'b0,
    parameter logic [1:0] RST_RNG  = 2'b00
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_wr_en,
    input  logic              cmd_wr_dis,
    input  logic              cmd_sts_wr,
    input  logic [7:0]        sts_wdata,
    input  logic              arr_wr_done,
    input  logic [ADDR_W-1:0] arr_addr,
    input  logic              lock_pin_n,
    input  logic              timer_busy,
    output logic [7:0]        sts_byte,
    output logic              arr_wr_ok,
    output logic              sts_wr_ok
);
    logic     wel;
    logic     in_prot;
    logic     hw_lock;
    logic     sts_commit;
    logic     wel_clr;
    nv_bits_t nv;

    // Permission logic: lock state, both grants and the commit strobe.
    always_comb begin
        hw_lock    = ~lock_pin_n & nv.lock_en;
        sts_wr_ok  = wel & ~timer_busy & ~hw_lock;
        arr_wr_ok  = wel & ~timer_busy & ~in_prot;
        sts_commit = cmd_sts_wr & sts_wr_ok;
        wel_clr    = cmd_wr_dis | arr_wr_done | sts_commit;
    end

    // Status byte assembly; the unused bits read as zero.
    always_comb begin
        sts_byte           = '0;
        sts_byte[POS_LOCK] = nv.lock_en;
        sts_byte[POS_RNG1] = nv.rng[1];
        sts_byte[POS_RNG0] = nv.rng[0];
        sts_byte[POS_WEL]  = wel;
        sts_byte[POS_BUSY] = timer_busy;
    end

    stsreg_wel u_wel (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_req (cmd_wr_en),
        .clr_req (wel_clr),
        .wel     (wel)
    );

    stsreg_nv #(
        .RST_LOCK (RST_LOCK),
        .RST_RNG  (RST_RNG)
    ) u_nv (
        .clk    (clk),
        .rst_n  (rst_n),
        .commit (sts_commit),
        .busy   (timer_busy),
        .wdata  (sts_wdata),
        .nv     (nv)
    );

    stsreg_range #(
        .ADDR_W (ADDR_W)
    ) u_range (
        .rng  (nv.rng),
        .addr (arr_addr),
        .prot (in_prot)
    );

    p_sts_commit_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_sts_wr && sts_wr_ok) |=> (sts_byte[POS_WEL] == 1'b0));
    p_locked_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_sts_wr && !lock_pin_n && sts_byte[POS_LOCK]) |=> $stable(sts_byte[7:2]));
    p_all_protected_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_byte[3:2] == 2'b11) |-> !arr_wr_ok);
    p_done_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        arr_wr_done |=> !sts_byte[POS_WEL]);
    p_busy_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
        timer_busy |-> (!arr_wr_ok && !sts_wr_ok));
endmodule

// File: tb/stsreg_guard_tb.sv
module stsreg_guard_tb;
    localparam int AW = 10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_wr_en = 1'b0, cmd_wr_dis = 1'b0, cmd_sts_wr = 1'b0;
    logic [7:0]    sts_wdata = 8'h00;
    logic          arr_wr_done = 1'b0;
    logic [AW-1:0] arr_addr = '0;
    logic          lock_pin_n = 1'b1;
    logic          timer_busy = 1'b0;
    logic [7:0]    sts_byte;
    logic          arr_wr_ok, sts_wr_ok;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    stsreg_guard #(.ADDR_W(AW)) u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_wr_en(cmd_wr_en), .cmd_wr_dis(cmd_wr_dis),
        .cmd_sts_wr(cmd_sts_wr), .sts_wdata(sts_wdata), .arr_wr_done(arr_wr_done),
        .arr_addr(arr_addr), .lock_pin_n(lock_pin_n), .timer_busy(timer_busy),
        .sts_byte(sts_byte), .arr_wr_ok(arr_wr_ok), .sts_wr_ok(sts_wr_ok)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One-cycle strobe set driven at a falling edge; returns one cycle later.
    task automatic strobe(input logic en, input logic dis, input logic sw,
                          input logic [7:0] d, input logic dn);
        @(negedge clk);
        cmd_wr_en = en; cmd_wr_dis = dis; cmd_sts_wr = sw; sts_wdata = d; arr_wr_done = dn;
        @(negedge clk);
        cmd_wr_en = 0; cmd_wr_dis = 0; cmd_sts_wr = 0; arr_wr_done = 0;
        #1;
    endtask

    function automatic logic exp_prot(input int rng, input int a);
        return (rng == 3) || (rng == 2 && a >= 512) || (rng == 1 && a >= 768);
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R2 reset status", sts_byte, 8'h00);
        check("R2 reset grants", {arr_wr_ok, sts_wr_ok}, 2'b00);

        for (int rng = 0; rng < 4; rng++) begin
            for (int le = 0; le < 2; le++) begin
                lock_pin_n = 1'b1;
                strobe(1, 0, 0, 8'h00, 0);
                check("R3 enable sets latch", sts_byte[1], 1'b1);
                strobe(0, 0, 1, {le[0], 3'b111, rng[1:0], 2'b11}, 0);
                check("R4 status load", sts_byte, {le[0], 3'b000, rng[1:0], 2'b00});
                strobe(1, 0, 0, 8'h00, 0);
                for (int pin = 0; pin < 2; pin++) begin
                    lock_pin_n = pin[0];
                    #1;
                    check("R5 status grant", sts_wr_ok, !(le == 1 && pin == 0));
                    for (int a = 0; a < 1024; a++) begin
                        arr_addr = a[AW-1:0];
                        #1;
                        check("R6 R7 array grant", arr_wr_ok, !exp_prot(rng, a));
                    end
                end
                strobe(0, 1, 0, 8'h00, 0);
                check("R3 disable clears latch", sts_byte[1], 1'b0);
                for (int a = 0; a < 1024; a += 64) begin
                    arr_addr = a[AW-1:0];
                    #1;
                    check("R7 no grant without latch", {arr_wr_ok, sts_wr_ok}, 2'b00);
                end
            end
        end

        // Lock engaged: status write refused, latch kept, array still open.
        lock_pin_n = 1'b1;
        strobe(1, 0, 0, 8'h00, 0);
        strobe(0, 0, 1, 8'h80, 0);
        check("R4 lock enable loaded", sts_byte, 8'h80);
        lock_pin_n = 1'b0;
        strobe(1, 0, 0, 8'h00, 0);
        check("R3 enable under lock", sts_byte, 8'h82);
        strobe(0, 0, 1, 8'h0C, 0);
        check("R5 locked write ignored", sts_byte, 8'h82);
        arr_addr = 10'h3FF; #1;
        check("R7 lock leaves array open", arr_wr_ok, 1'b1);

        // Busy: mirror, grants off, persistent bits frozen.
        timer_busy = 1'b1; #1;
        check("R1 busy mirrored", sts_byte, 8'h83);
        check("R7 busy blocks", {arr_wr_ok, sts_wr_ok}, 2'b00);
        lock_pin_n = 1'b1;
        strobe(0, 0, 1, 8'h0C, 0);
        lock_pin_n = 1'b0;
        strobe(0, 0, 1, 8'h00, 0);
        check("R10 bits frozen while busy", sts_byte, 8'h83);
        strobe(0, 1, 0, 8'h00, 0);
        check("R3 disable while busy", sts_byte, 8'h81);
        strobe(1, 0, 0, 8'h00, 0);
        timer_busy = 1'b0;
        strobe(0, 0, 0, 8'h00, 1);
        check("R8 completion clears latch", sts_byte, 8'h80);

        // Collisions of set and clear.
        strobe(1, 0, 0, 8'h00, 0);
        strobe(1, 0, 0, 8'h00, 1);
        check("R9 enable with completion", sts_byte[1], 1'b0);
        strobe(1, 0, 0, 8'h00, 0);
        strobe(1, 1, 0, 8'h00, 0);
        check("R9 enable with disable", sts_byte[1], 1'b0);
        lock_pin_n = 1'b1;
        strobe(1, 0, 0, 8'h00, 0);
        strobe(1, 0, 1, 8'h00, 0);
        check("R9 enable with status write", sts_byte, 8'h00);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule